// File: doc/BRIEF.md
# UART Host Bus Register Decoder

This block is the processor-facing register front end of a 16C550-style UART with an extended register set. A host drives an 8-bit data bus, a 3-bit address, an active-low chip select and separate active-low read and write strobes. The block holds the control registers and drives read data. It also emits single-clock pulses that tell the transmit, receive and FIFO logic when their locations were touched. Status from the shifters, FIFOs and interrupt logic arrives on plain inputs and is only multiplexed onto the read bus.

A bus cycle exists only while chip select and a strobe are both low. The host may lower or raise the two signals in either order. All three control pins pass through a two-flop synchronizer. A write takes effect one clock after the synchronized cycle is seen to end, so the data is taken as it stood at the end of the cycle.

The Line Control Register picks the view at each address. With its top bit clear the normal bank is visible. With the top bit set, the two lowest addresses reach the baud divisor latches. When both latches are zero, those two addresses instead read back a revision code and an identification code. One key value of the Line Control Register opens a separate bank that holds the enhanced feature register and four flow-control characters.

Top module: `uart_hostbus_regs`

## Requirements
- R1: A bus cycle exists only while `cs_n` and the strobe (`rd_n` or `wr_n`) are both low, whichever falls second and whichever rises first. Each pin is seen two rising edges after it changes. `rdata_oe` is high exactly while the synchronized read cycle lasts, and `rdata` is 0x00 whenever `rdata_oe` is low.
- R2: A write cycle commits exactly once. The target register and any write pulse change at the third rising edge after the first release edge. `thr_wr`, `fcr_wr` and `rx_rd` are each one clock wide.
- R3: With LCR[7]=0, a write to address 0 pulses `thr_wr` and updates `thr_data`. A read of address 0 returns `rbr_in`, and `rx_rd` pulses when that read cycle ends. Address 1 is the read/write interrupt enable register.
- R4: Outside the enhanced bank, a write to address 2 loads `fcr_q` and pulses `fcr_wr`. A read of address 2 returns `isr_in`.
- R5: Address 3 is the read/write LCR in every bank. Outside the enhanced bank, address 4 is the read/write MCR and address 7 is a read/write scratch byte. Writes to addresses 5 and 6 load `xfr_q` and `irpw_q`, and reads of those addresses return `lsr_in` and `msr_in`.
- R6: With LCR[7]=1 and LCR not equal to 0xBF, addresses 0 and 1 read and write DLL and DLM, except where R7 applies to a read.
- R7: With LCR[7]=1 and DLL=DLM=0x00, a read of address 0 returns the revision code (parameter, default 0x03) and a read of address 1 returns the device code (parameter, default 0x05).
- R8: With LCR=0xBF, address 2 is the read/write EFR and addresses 4, 5, 6, 7 are XON1, XON2, XOFF1, XOFF2. Writes to addresses 0 and 1 change nothing, and reads of them return 0x00 unless R7 applies.
- R9: Reset clears every register output and every pulse to 0x00 and forces `rdata_oe` low.
- R10: EFR and the flow characters change only while LCR=0xBF. DLL and DLM change only while LCR[7]=1. IER changes only while LCR[7]=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | DW | Write data from host |
| rbr_in | input | DW | Receive holding byte from receiver |
| isr_in | input | DW | Interrupt status byte (bit 5 auto flow event, bit 4 software flow or special character) |
| lsr_in | input | DW | Line status byte |
| msr_in | input | DW | Modem status byte |
| rdata | output | DW | Read data, 0x00 outside a read cycle |
| rdata_oe | output | 1 | High while a read cycle is active |
| thr_wr | output | 1 | One-clock pulse: transmit byte written |
| thr_data | output | DW | Last byte written to the transmit location |
| rx_rd | output | 1 | One-clock pulse: receive byte read |
| fcr_wr | output | 1 | One-clock pulse: FIFO control written |
| lcr_q | output | DW | Line control |
| ier_q | output | DW | Interrupt enable (bit 7 auto-CTS, bit 6 auto-RTS, bit 5 Xoff) |
| fcr_q | output | DW | FIFO control (bits 5:4 transmit trigger level) |
| mcr_q | output | DW | Modem control (bit 7 prescaler, bit 6 infrared, bit 5 interrupt type, bit 3 OP2 / interrupt output enable) |
| xfr_q | output | DW | Extra feature byte |
| irpw_q | output | DW | Infrared pulse-width byte |
| spr_q | output | DW | Scratch byte |
| dll_q | output | DW | Divisor latch low |
| dlm_q | output | DW | Divisor latch high |
| efr_q | output | DW | Enhanced feature byte |
| xon1_q | output | DW | First start character |
| xon2_q | output | DW | Second start character |
| xoff1_q | output | DW | First stop character |
| xoff2_q | output | DW | Second stop character |

## Verification
The assertions assume that the host never has its read and write strobes low at the same time while chip select is asserted. They also assume that each level on the control pins lasts at least two clocks, so that every edge survives the synchronizer. The stimulus changes pins only just after a rising edge. It holds every assertion or release phase for several clocks and keeps address and write data unchanged from before a cycle until well after it ends. Each write is followed by an idle gap before the next cycle, so an end of cycle never meets the start of another inside the synchronizer window.

// File: rtl/uart_hostbus_regs.sv
module uart_hostbus_regs #(
  parameter int DW = 8,
  parameter int SYNC = 2,
  parameter logic [DW-1:0] REV_CODE = 'h03,
  parameter logic [DW-1:0] ID_CODE  = 'h05,
  parameter logic [DW-1:0] ENH_KEY  = 'hBF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rbr_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          thr_wr,
  output logic [DW-1:0] thr_data,
  output logic          rx_rd,
  output logic          fcr_wr,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] ier_q,
  output logic [DW-1:0] fcr_q,
  output logic [DW-1:0] mcr_q,
  output logic [DW-1:0] xfr_q,
  output logic [DW-1:0] irpw_q,
  output logic [DW-1:0] spr_q,
  output logic [DW-1:0] dll_q,
  output logic [DW-1:0] dlm_q,
  output logic [DW-1:0] efr_q,
  output logic [DW-1:0] xon1_q,
  output logic [DW-1:0] xon2_q,
  output logic [DW-1:0] xoff1_q,
  output logic [DW-1:0] xoff2_q
);

  logic [SYNC-1:0] cs_sh, rd_sh, wr_sh;
  logic            rd_act, wr_act, rd_prev, wr_prev, rd_end, wr_end;
  logic [2:0]      lat_addr;
  logic [DW-1:0]   lat_data, rd_mux;
  logic            dlab, enh, id_view;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sh <= '1;
      rd_sh <= '1;
      wr_sh <= '1;
    end else begin
      cs_sh <= {cs_sh[SYNC-2:0], cs_n};
      rd_sh <= {rd_sh[SYNC-2:0], rd_n};
      wr_sh <= {wr_sh[SYNC-2:0], wr_n};
    end

  assign rd_act = ~cs_sh[SYNC-1] & ~rd_sh[SYNC-1];
  assign wr_act = ~cs_sh[SYNC-1] & ~wr_sh[SYNC-1];
  assign rd_end = rd_prev & ~rd_act;
  assign wr_end = wr_prev & ~wr_act;

  assign dlab    = lcr_q[7];
  assign enh     = (lcr_q == ENH_KEY);
  assign id_view = dlab && dll_q == '0 && dlm_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      wr_prev  <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
      if (rd_act || wr_act) begin
        lat_addr <= addr;
        lat_data <= wdata;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr_wr <= 1'b0; rx_rd <= 1'b0; fcr_wr <= 1'b0; thr_data <= '0;
      lcr_q <= '0; ier_q <= '0; fcr_q <= '0; mcr_q <= '0;
      xfr_q <= '0; irpw_q <= '0; spr_q <= '0; dll_q <= '0; dlm_q <= '0;
      efr_q <= '0; xon1_q <= '0; xon2_q <= '0; xoff1_q <= '0; xoff2_q <= '0;
    end else begin
      thr_wr <= 1'b0;
      fcr_wr <= 1'b0;
      rx_rd  <= rd_end && lat_addr == 3'd0 && !dlab;
      if (wr_end) begin
        case (lat_addr)
          3'd0: if (!enh) begin
                  if (dlab) dll_q <= lat_data;
                  else begin thr_wr <= 1'b1; thr_data <= lat_data; end
                end
          3'd1: if (!enh) begin
                  if (dlab) dlm_q <= lat_data;
                  else      ier_q <= lat_data;
                end
          3'd2: if (enh) efr_q <= lat_data;
                else begin fcr_q <= lat_data; fcr_wr <= 1'b1; end
          3'd3: lcr_q <= lat_data;
          3'd4: if (enh) xon1_q  <= lat_data; else mcr_q  <= lat_data;
          3'd5: if (enh) xon2_q  <= lat_data; else xfr_q  <= lat_data;
          3'd6: if (enh) xoff1_q <= lat_data; else irpw_q <= lat_data;
          default: if (enh) xoff2_q <= lat_data; else spr_q <= lat_data;
        endcase
      end
    end

  always_comb begin
    rd_mux = '0;
    case (addr)
      3'd0: rd_mux = !dlab ? rbr_in : id_view ? REV_CODE : enh ? '0 : dll_q;
      3'd1: rd_mux = !dlab ? ier_q  : id_view ? ID_CODE  : enh ? '0 : dlm_q;
      3'd2: rd_mux = enh ? efr_q   : isr_in;
      3'd3: rd_mux = lcr_q;
      3'd4: rd_mux = enh ? xon1_q  : mcr_q;
      3'd5: rd_mux = enh ? xon2_q  : lsr_in;
      3'd6: rd_mux = enh ? xoff1_q : msr_in;
      default: rd_mux = enh ? xoff2_q : spr_q;
    endcase
  end

  assign rdata_oe = rd_act;
  assign rdata    = rd_act ? rd_mux : '0;

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_act && wr_act));
  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> rdata_oe);
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr || fcr_wr) |=> !(thr_wr || fcr_wr));
  assert_rx_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !rx_rd);
  assert_enh_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({efr_q, xon1_q, xon2_q, xoff1_q, xoff2_q}) |-> $past(lcr_q) == ENH_KEY);
  assert_dl_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dll_q, dlm_q}) |-> $past(lcr_q[7]));
  assert_ier_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ier_q) |-> !$past(lcr_q[7]));

endmodule

// File: tb/uart_hostbus_regs_test.sv
module uart_hostbus_regs_test;
  localparam logic [7:0] REV = 8'h2C;
  localparam logic [7:0] DID = 8'h71;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rbr_in = 8'h99, isr_in = 8'hC4, lsr_in = 8'h60, msr_in = 8'hB0;
  logic [7:0] rdata, thr_data, lcr_q, ier_q, fcr_q, mcr_q, xfr_q, irpw_q, spr_q;
  logic [7:0] dll_q, dlm_q, efr_q, xon1_q, xon2_q, xoff1_q, xoff2_q;
  logic rdata_oe, thr_wr, rx_rd, fcr_wr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_hostbus_regs #(.DW(8), .SYNC(2), .REV_CODE(REV), .ID_CODE(DID), .ENH_KEY(8'hBF)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rbr_in(rbr_in), .isr_in(isr_in), .lsr_in(lsr_in), .msr_in(msr_in),
    .rdata(rdata), .rdata_oe(rdata_oe), .thr_wr(thr_wr), .thr_data(thr_data),
    .rx_rd(rx_rd), .fcr_wr(fcr_wr), .lcr_q(lcr_q), .ier_q(ier_q), .fcr_q(fcr_q),
    .mcr_q(mcr_q), .xfr_q(xfr_q), .irpw_q(irpw_q), .spr_q(spr_q), .dll_q(dll_q),
    .dlm_q(dlm_q), .efr_q(efr_q), .xon1_q(xon1_q), .xon2_q(xon2_q),
    .xoff1_q(xoff1_q), .xoff2_q(xoff2_q));

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  logic [7:0] m_lcr, m_ier, m_fcr, m_mcr, m_xfr, m_irpw, m_spr, m_dll, m_dlm;
  logic [7:0] m_efr, m_x1, m_x2, m_xf1, m_xf2, m_thr, m_la, m_ld;
  bit e_thr, e_fcr, e_rx, e_oe;
  bit w1, w2, w3, r1, r2, r3;

  function automatic logic [7:0] m_read(logic [2:0] a);
    bit hi = m_lcr[7];
    bit key = (m_lcr == 8'hBF);
    bit idv = hi && m_dll == 0 && m_dlm == 0;
    if (a == 0 && hi) return idv ? REV : (key ? 8'h00 : m_dll);
    if (a == 1 && hi) return idv ? DID : (key ? 8'h00 : m_dlm);
    if (a == 3) return m_lcr;
    if (key) begin
      if (a == 2) return m_efr;
      if (a == 4) return m_x1;
      if (a == 5) return m_x2;
      if (a == 6) return m_xf1;
      if (a == 7) return m_xf2;
    end
    if (a == 0) return rbr_in;
    if (a == 1) return m_ier;
    if (a == 2) return isr_in;
    if (a == 4) return m_mcr;
    if (a == 5) return lsr_in;
    if (a == 6) return msr_in;
    return m_spr;
  endfunction

  function automatic string m_tag(logic [2:0] a);
    if (a <= 1 && m_lcr[7]) return (m_dll == 0 && m_dlm == 0) ? "R7" : (m_lcr == 8'hBF ? "R8" : "R6");
    if (m_lcr == 8'hBF && a != 3) return "R8";
    if (a <= 1) return "R3";
    if (a == 2) return "R4";
    return "R5";
  endfunction

  function automatic void m_write(logic [2:0] a, logic [7:0] d);
    bit key = (m_lcr == 8'hBF);
    if (a == 3) m_lcr = d;
    else if (key) begin
      case (a)
        2: m_efr = d;
        4: m_x1 = d;
        5: m_x2 = d;
        6: m_xf1 = d;
        7: m_xf2 = d;
        default: ;
      endcase
    end else if (a == 0) begin
      if (m_lcr[7]) m_dll = d; else begin e_thr = 1; m_thr = d; end
    end else if (a == 1) begin
      if (m_lcr[7]) m_dlm = d; else m_ier = d;
    end else if (a == 2) begin m_fcr = d; e_fcr = 1; end
    else if (a == 4) m_mcr = d;
    else if (a == 5) m_xfr = d;
    else if (a == 6) m_irpw = d;
    else m_spr = d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_lcr, m_ier, m_fcr, m_mcr, m_xfr, m_irpw, m_spr, m_dll, m_dlm} = '0;
      {m_efr, m_x1, m_x2, m_xf1, m_xf2, m_thr, m_la, m_ld} = '0;
      {e_thr, e_fcr, e_rx, e_oe, w1, w2, w3, r1, r2, r3} = '0;
    end else begin
      e_thr = 0; e_fcr = 0;
      e_rx = r3 && !r2 && m_la == 0 && !m_lcr[7];
      if (w3 && !w2) m_write(m_la, m_ld);
      if (w2 || r2) begin m_la = addr; m_ld = wdata; end
      w3 = w2; w2 = w1; w1 = !cs_n && !wr_n;
      r3 = r2; r2 = r1; r1 = !cs_n && !rd_n;
      e_oe = r2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "rdata_oe", {7'b0, rdata_oe}, {7'b0, e_oe});
      chk(e_oe ? m_tag(addr) : "R1", "rdata", rdata, e_oe ? m_read(addr) : 8'h00);
      chk("R3", "thr_wr", {7'b0, thr_wr}, {7'b0, e_thr});
      chk("R3", "thr_data", thr_data, m_thr);
      chk("R3", "rx_rd", {7'b0, rx_rd}, {7'b0, e_rx});
      chk("R4", "fcr_wr", {7'b0, fcr_wr}, {7'b0, e_fcr});
      chk("R4", "fcr_q", fcr_q, m_fcr);
      chk("R5", "lcr_q", lcr_q, m_lcr);
      chk("R3", "ier_q", ier_q, m_ier);
      chk("R5", "mcr_q", mcr_q, m_mcr);
      chk("R5", "xfr_q", xfr_q, m_xfr);
      chk("R5", "irpw_q", irpw_q, m_irpw);
      chk("R5", "spr_q", spr_q, m_spr);
      chk("R6", "dll_q", dll_q, m_dll);
      chk("R6", "dlm_q", dlm_q, m_dlm);
      chk("R8", "efr_q", efr_q, m_efr);
      chk("R8", "xon1_q", xon1_q, m_x1);
      chk("R8", "xon2_q", xon2_q, m_x2);
      chk("R8", "xoff1_q", xoff1_q, m_xf1);
      chk("R8", "xoff2_q", xoff2_q, m_xf2);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // one bus cycle; cs_lead: chip select falls first; cs_trail: chip select rises last
  task automatic bus(bit is_wr, logic [2:0] a, logic [7:0] d, bit cs_lead, bit cs_trail,
                     output logic [7:0] seen);
    addr = a; wdata = d; step(1);
    if (cs_lead) begin cs_n = 0; step(2); if (is_wr) wr_n = 0; else rd_n = 0; end
    else begin if (is_wr) wr_n = 0; else rd_n = 0; step(2); cs_n = 0; end
    step(3);
    seen = rdata;
    step(1);
    if (cs_trail) begin rd_n = 1; wr_n = 1; step(2); cs_n = 1; end
    else begin cs_n = 1; step(2); rd_n = 1; wr_n = 1; end
    step(5);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    logic [7:0] s;
    bus(1, a, d, 1, 1, s);
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    logic [7:0] s;
    bus(0, a, 8'h00, 0, 0, s);
    chk(tag, "read", s, exp);
  endtask

  initial begin
    logic [7:0] s;
    step(3);
    chk("R9", "reset lcr", lcr_q, 8'h00);
    chk("R9", "reset ier/dl", ier_q | dll_q | dlm_q, 8'h00);
    chk("R9", "reset mcr/efr", mcr_q | efr_q, 8'h00);
    chk("R9", "reset xon/xoff", xon1_q | xon2_q | xoff1_q | xoff2_q, 8'h00);
    chk("R9", "reset oe/pulses", {4'b0, rdata_oe, thr_wr, rx_rd, fcr_wr}, 8'h00);
    rst_n = 1;
    step(2);

    wr(3, 8'h03);
    rd(3, 8'h03, "R5");
    bus(1, 1, 8'hE0, 1, 0, s);                  // R1 chip select leads and releases first
    rd(1, 8'hE0, "R3");
    bus(1, 7, 8'h5A, 0, 1, s);                  // R1 strobe leads, chip select releases last
    bus(0, 7, 8'h00, 1, 1, s);
    chk("R1", "scratch after mixed order", s, 8'h5A);

    addr = 7; wdata = 8'hEE; step(1);           // R1 no cycle without both signals
    cs_n = 0; step(4); cs_n = 1; step(3);
    wr_n = 0; step(4); wr_n = 1; step(6);
    chk("R1", "chip select alone / strobe alone", spr_q, 8'h5A);

    wr(2, 8'h30);
    chk("R4", "fcr trigger bits", fcr_q, 8'h30);
    rd(2, 8'hC4, "R4");
    wr(5, 8'h11);
    wr(6, 8'h22);
    rd(5, 8'h60, "R5");
    rd(6, 8'hB0, "R5");
    chk("R5", "xfr/irpw", xfr_q ^ irpw_q, 8'h33);
    wr(4, 8'hE8);
    rd(4, 8'hE8, "R5");
    wr(0, 8'h41);
    chk("R3", "thr data", thr_data, 8'h41);
    rd(0, 8'h99, "R3");

    // R2 commit timing
    addr = 7; wdata = 8'h77; step(1);
    cs_n = 0; step(2); wr_n = 0; step(4);
    wr_n = 1; step(1);
    chk("R2", "no commit after 1 edge", spr_q, 8'h5A);
    step(1);
    chk("R2", "no commit after 2 edges", spr_q, 8'h5A);
    step(1);
    chk("R2", "commit at 3rd edge", spr_q, 8'h77);
    cs_n = 1; step(6);

    wr(3, 8'h83);
    rd(0, REV, "R7");
    rd(1, DID, "R7");
    wr(0, 8'h0C);
    rd(0, 8'h0C, "R6");
    rd(1, 8'h00, "R6");
    wr(1, 8'h01);
    chk("R6", "dlm write", dlm_q, 8'h01);
    chk("R10", "ier kept while divisor view open", ier_q, 8'hE0);

    wr(3, 8'hBF);
    wr(2, 8'h10);
    wr(4, 8'h11); wr(5, 8'h13); wr(6, 8'h19); wr(7, 8'h93);
    rd(2, 8'h10, "R8");
    rd(7, 8'h93, "R8");
    chk("R8", "xon1/xoff1", {xon1_q[3:0], xoff1_q[3:0]}, 8'h19);
    wr(0, 8'hFF);
    wr(1, 8'hFF);
    chk("R8", "dll ignored in enhanced bank", dll_q, 8'h0C);
    chk("R8", "fcr untouched by efr write", fcr_q, 8'h30);
    rd(0, 8'h00, "R8");

    wr(3, 8'h03);
    wr(4, 8'h0B);
    chk("R10", "xon1 kept outside enhanced bank", xon1_q, 8'h11);
    chk("R5", "mcr in normal bank", mcr_q, 8'h0B);
    wr(1, 8'h20);
    chk("R10", "dlm kept with LCR[7]=0", dlm_q, 8'h01);

    wr(3, 8'h80); wr(0, 8'h00); wr(1, 8'h00);
    wr(3, 8'hBF);
    rd(0, REV, "R7");
    rd(1, DID, "R7");
    wr(3, 8'h00);

    rbr_in = 8'h3C; step(2);
    rd(0, 8'h3C, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule